// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit with Status Flags

This block is the data path of an 8-bit accumulator machine. Each cycle it takes the current accumulator, a second operand that the surrounding core has already fetched (from a register, an on-chip address, through a pointer or from the instruction stream), the current carry flag and a 4-bit operation code. It returns the new accumulator value and a write-back value for the operand's home at once, with no register on the path.

The four status flags sit in a small register inside the block. These are carry, auxiliary (half) carry, signed overflow and accumulator parity. The flag register loads on the clock edge where `op_valid_i` is high. Each operation class writes only its own subset of flags. A flag that an operation leaves alone keeps its stored value, except carry. When an operation does not compute carry, the carry flag is reloaded from `cy_i`, so the flag register always follows the carry that the core presented.

The operations are add, add with carry, subtract with borrow, AND, OR, XOR, increment, the four rotates, nibble swap and the low-nibble exchange between the accumulator and the operand. Multiply, divide and decimal adjust are handled elsewhere.

Top module: `acc_alu`

## Requirements
- R1: Op 0 (add) gives res_o = (acc_i + opnd_i) mod 256. Carry is set when the sum exceeds 255. Auxiliary carry is set when the sum of the low nibbles exceeds 15. Overflow is set when the signed sum lies outside -128..127.
- R2: Op 1 (add with carry) behaves like op 0, but adds cy_i into the sum, into the low-nibble sum and into the signed sum.
- R3: Op 2 (subtract with borrow) gives res_o = (acc_i - cy_i - opnd_i) mod 256. Carry is set when the true difference is negative. Auxiliary carry is set when acc_i[3:0] - opnd_i[3:0] - cy_i is negative. Overflow is set when the signed difference lies outside -128..127.
- R4: Ops 3, 4 and 5 (AND, OR, XOR) give the bitwise result. They load carry from cy_i and leave auxiliary carry and overflow unchanged.
- R5: Op 6 gives res_o = (acc_i + 1) mod 256. It loads carry from cy_i and leaves auxiliary carry and overflow unchanged, including on the wrap from 0xFF to 0x00.
- R6: Ops 7 and 9 rotate the accumulator left or right by one place and load carry from cy_i. Ops 8 and 10 rotate through carry: cy_i fills the vacated bit, and the bit shifted out (bit 7 for left, bit 0 for right) becomes the new carry. All four rotates leave auxiliary carry and overflow unchanged.
- R7: Op 11 gives res_o = {acc_i[3:0], acc_i[7:4]}. Carry is loaded from cy_i, and auxiliary carry and overflow are unchanged.
- R8: Op 12 gives res_o = {acc_i[7:4], opnd_i[3:0]} and opnd_wb_o = {opnd_i[7:4], acc_i[3:0]}. For every other op, opnd_wb_o equals opnd_i.
- R9: After every accepted op, par_o is the XOR of the 8 bits of that op's res_o, so the accumulator plus the flag always holds an even number of ones.
- R10: Flags change only on a rising clk edge with op_valid_i high. With op_valid_i low they hold. An active-low rst_n clears all four flags to 0.
- R11: Ops 13 to 15 pass acc_i through unchanged. They load carry from cy_i, hold auxiliary carry and overflow, and update parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_valid_i | input | 1 | Load the flag register at this edge |
| op_i | input | 4 | Operation code, 0 to 15 |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Second operand, already fetched |
| cy_i | input | 1 | Current carry flag |
| res_o | output | 8 | New accumulator value (combinational) |
| opnd_wb_o | output | 8 | Value to write back to the operand location |
| cy_o | output | 1 | Stored carry flag |
| ac_o | output | 1 | Stored auxiliary carry flag |
| ov_o | output | 1 | Stored overflow flag |
| par_o | output | 1 | Stored accumulator parity flag |

## Verification
The pair of functions that can land in the same cycle is a result that ends the arithmetic chain and a flag that must keep its old value. An arithmetic op leaves auxiliary carry and overflow set or clear. The next op is a logic op, increment, rotate or swap, and it must reload carry from cy_i while holding those two flags. The stimulus sweeps every op code over all 256 accumulator values, a set of operands chosen to sit on nibble and sign boundaries, and both carry values. Because the op codes are interleaved, each held flag carries over from a different arithmetic result. The scoreboard keeps its own copy of the held flags and judges carry, auxiliary carry, overflow and parity on the edge after each op, alongside the combinational results.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid_i,
  input  logic [OPW-1:0] op_i,
  input  logic [7:0]     acc_i,
  input  logic [7:0]     opnd_i,
  input  logic           cy_i,
  output logic [7:0]     res_o,
  output logic [7:0]     opnd_wb_o,
  output logic           cy_o,
  output logic           ac_o,
  output logic           ov_o,
  output logic           par_o
);
  localparam logic [OPW-1:0] OP_ADD  = OPW'(0);
  localparam logic [OPW-1:0] OP_ADDC = OPW'(1);
  localparam logic [OPW-1:0] OP_SUBB = OPW'(2);
  localparam logic [OPW-1:0] OP_AND  = OPW'(3);
  localparam logic [OPW-1:0] OP_OR   = OPW'(4);
  localparam logic [OPW-1:0] OP_XOR  = OPW'(5);
  localparam logic [OPW-1:0] OP_INC  = OPW'(6);
  localparam logic [OPW-1:0] OP_RL   = OPW'(7);
  localparam logic [OPW-1:0] OP_RLC  = OPW'(8);
  localparam logic [OPW-1:0] OP_RR   = OPW'(9);
  localparam logic [OPW-1:0] OP_RRC  = OPW'(10);
  localparam logic [OPW-1:0] OP_SWAP = OPW'(11);
  localparam logic [OPW-1:0] OP_XCHD = OPW'(12);

  logic       is_sub, is_arith, ci;
  logic [7:0] b_eff;
  logic [4:0] lo;
  logic [3:0] mid;
  logic [1:0] hi;
  logic       nx_cy, nx_ac, nx_ov;

  assign is_sub   = (op_i == OP_SUBB);
  assign is_arith = (op_i == OP_ADD) || (op_i == OP_ADDC) || is_sub;
  assign b_eff    = is_sub ? ~opnd_i : opnd_i;
  assign ci       = is_sub ? ~cy_i : ((op_i == OP_ADDC) & cy_i);

  assign lo  = {1'b0, acc_i[3:0]} + {1'b0, b_eff[3:0]} + {4'd0, ci};
  assign mid = {1'b0, acc_i[6:4]} + {1'b0, b_eff[6:4]} + {3'd0, lo[4]};
  assign hi  = {1'b0, acc_i[7]} + {1'b0, b_eff[7]} + {1'b0, mid[3]};

  always_comb begin
    res_o     = acc_i;
    opnd_wb_o = opnd_i;
    nx_cy     = cy_i;
    nx_ac     = ac_o;
    nx_ov     = ov_o;
    if (is_arith) begin
      res_o = {hi[0], mid[2:0], lo[3:0]};
      nx_cy = hi[1] ^ is_sub;
      nx_ac = lo[4] ^ is_sub;
      nx_ov = hi[1] ^ mid[3];
    end else begin
      case (op_i)
        OP_AND:  res_o = acc_i & opnd_i;
        OP_OR:   res_o = acc_i | opnd_i;
        OP_XOR:  res_o = acc_i ^ opnd_i;
        OP_INC:  res_o = acc_i + 8'd1;
        OP_RL:   res_o = {acc_i[6:0], acc_i[7]};
        OP_RLC:  begin res_o = {acc_i[6:0], cy_i}; nx_cy = acc_i[7]; end
        OP_RR:   res_o = {acc_i[0], acc_i[7:1]};
        OP_RRC:  begin res_o = {cy_i, acc_i[7:1]}; nx_cy = acc_i[0]; end
        OP_SWAP: res_o = {acc_i[3:0], acc_i[7:4]};
        OP_XCHD: begin
          res_o     = {acc_i[7:4], opnd_i[3:0]};
          opnd_wb_o = {opnd_i[7:4], acc_i[3:0]};
        end
        default: res_o = acc_i;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_o  <= 1'b0;
      ac_o  <= 1'b0;
      ov_o  <= 1'b0;
      par_o <= 1'b0;
    end else if (op_valid_i) begin
      cy_o  <= nx_cy;
      ac_o  <= nx_ac;
      ov_o  <= nx_ov;
      par_o <= ^res_o;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> $stable({cy_o, ac_o, ov_o, par_o})); // R10
  AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i |=> ((^{par_o, $past(res_o)}) == 1'b0)); // R9
  AST_LOGIC_KEEPS_AC_OV: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)
    |=> $stable({ac_o, ov_o}) && cy_o == $past(cy_i)); // R4
  AST_INC_KEEPS_AC_OV: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i && op_i == OP_INC |=> $stable({ac_o, ov_o}) && cy_o == $past(cy_i)); // R5
  AST_PLAIN_ROT_CY: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i && (op_i == OP_RL || op_i == OP_RR) |=> cy_o == $past(cy_i)); // R6
  AST_RLC_OUT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i && op_i == OP_RLC |=> cy_o == $past(acc_i[7])); // R6
  AST_XCHD_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_XCHD |-> res_o[7:4] == acc_i[7:4] && opnd_wb_o[7:4] == opnd_i[7:4]); // R8
  AST_WB_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    op_i != OP_XCHD |-> opnd_wb_o == opnd_i); // R8
endmodule

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic       cy_i = 1'b0;
  logic [7:0] res_o, opnd_wb_o;
  logic       cy_o, ac_o, ov_o, par_o;

  always #2 clk = ~clk;

  acc_alu i_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .cy_i(cy_i), .res_o(res_o),
    .opnd_wb_o(opnd_wb_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o), .par_o(par_o)
  );

  typedef struct {
    int op; int a; int b; int c;
    logic [7:0] res; logic [7:0] wb;
    logic cy; logic ac; logic ov; logic p;
  } item_t;

  item_t sbq[$];
  int n_vec = 0, n_bad = 0;
  logic m_ac = 1'b0, m_ov = 1'b0;
  logic [7:0] opset [16] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'h81, 8'hFE,
                             8'hFF, 8'h55, 8'hAA, 8'h39, 8'hC6, 8'h08, 8'hF0, 8'h6B};

  function automatic string req_of(int op);
    case (op)
      0: return "R1";   1: return "R2";   2: return "R3";
      3, 4, 5: return "R4";
      6: return "R5";
      7, 8, 9, 10: return "R6";
      11: return "R7";  12: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  task automatic fail(string req, string what, int act, int exp);
    n_bad++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic drive(int op, int a, int b, int c);
    item_t it;
    int r, s, nc, ones;
    r = a; nc = c;
    it.wb = 8'(b);
    it.ac = m_ac; it.ov = m_ov;
    case (op)
      0, 1: begin
        s = (op == 1) ? c : 0;
        r = (a + b + s) % 256;
        nc = ((a + b + s) > 255) ? 1 : 0;
        it.ac = ((a % 16) + (b % 16) + s) > 15;
        it.ov = ((sgn(a) + sgn(b) + s) > 127) || ((sgn(a) + sgn(b) + s) < -128);
      end
      2: begin
        s = a - b - c;
        r = (s + 512) % 256;
        nc = (s < 0) ? 1 : 0;
        it.ac = ((a % 16) - (b % 16) - c) < 0;
        it.ov = ((sgn(a) - sgn(b) - c) > 127) || ((sgn(a) - sgn(b) - c) < -128);
      end
      3: r = a & b;
      4: r = a | b;
      5: r = a ^ b;
      6: r = (a + 1) % 256;
      7: r = ((a * 2) % 256) + (a / 128);
      8: begin r = ((a * 2) % 256) + c; nc = a / 128; end
      9: r = (a / 2) + (a % 2) * 128;
      10: begin r = (a / 2) + c * 128; nc = a % 2; end
      11: r = (a % 16) * 16 + (a / 16);
      12: begin
        r = (a / 16) * 16 + (b % 16);
        it.wb = 8'((b / 16) * 16 + (a % 16));
      end
      default: r = a;
    endcase
    ones = 0;
    for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
    it.op = op; it.a = a; it.b = b; it.c = c;
    it.res = 8'(r); it.cy = nc[0]; it.p = ones[0];
    m_ac = it.ac; m_ov = it.ov;
    @(negedge clk);
    op_valid_i = 1'b1; op_i = 4'(op); acc_i = 8'(a); opnd_i = 8'(b); cy_i = c[0];
    sbq.push_back(it);
  endtask

  initial begin : monitor
    item_t e;
    string q;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        q = req_of(e.op);
        n_vec++;
        if (res_o !== e.res) fail(q, "res", res_o, e.res);
        if (opnd_wb_o !== e.wb) fail("R8", "wb", opnd_wb_o, e.wb);
        if (cy_o !== e.cy) fail(q, "cy", cy_o, e.cy);
        if (ac_o !== e.ac) fail(q, "ac", ac_o, e.ac);
        if (ov_o !== e.ov) fail(q, "ov", ov_o, e.ov);
        if (par_o !== e.p) fail("R9", "par", par_o, e.p);
      end
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog expired actual=%0h expected=%0h", n_vec, 0);
    finish_run();
  end

  initial begin : stim
    logic [3:0] held;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if ({cy_o, ac_o, ov_o, par_o} !== 4'b0000)
      fail("R10", "reset flags", {cy_o, ac_o, ov_o, par_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 R2 R3: carry, half carry and overflow corners
    drive(0, 8'h7F, 8'h01, 0);
    drive(0, 8'hFF, 8'h01, 0);
    drive(1, 8'h0F, 8'h00, 1);
    drive(2, 8'h80, 8'h00, 1);
    drive(2, 8'h00, 8'h00, 1);
    // R5: wrap from 0xFF keeps ac/ov from the previous subtract
    drive(6, 8'hFF, 8'h00, 0);
    // R10: idle cycles with changing inputs must not move the flags
    @(negedge clk);
    op_valid_i = 1'b0;
    while (sbq.size() > 0) @(posedge clk);
    @(negedge clk);
    held = {cy_o, ac_o, ov_o, par_o};
    op_i = 4'd0; acc_i = 8'hFF; opnd_i = 8'hFF; cy_i = 1'b1;
    repeat (3) @(negedge clk);
    n_vec++;
    if ({cy_o, ac_o, ov_o, par_o} !== held)
      fail("R10", "idle hold", {cy_o, ac_o, ov_o, par_o}, held);
    // sweep: all ops (R1..R11), all accumulators, edge operands, both carries
    for (int a = 0; a < 256; a++)
      for (int j = 0; j < 16; j++)
        for (int c = 0; c < 2; c++)
          for (int op = 0; op < 16; op++)
            drive((op + a + j) % 16, a, opset[j], c);
    @(negedge clk);
    op_valid_i = 1'b0;
    while (sbq.size() > 0) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule